// File: doc/BRIEF.md
# Dual-Mode Cartridge Address Decoder

This block sits between a host CPU bus and the memories of a cartridge that carries a coprocessor. Every cycle it takes the 24-bit host address, the read and write requests, a one-bit strap that selects one of two memory maps, and two status bits from the coprocessor. It returns a one-hot region select, the linear offset inside that region, and read and write strobes that are already qualified by the select. The regions are program ROM, battery-backed RAM, the coprocessor's internal data RAM, the control I/O space, and unmapped.

In some cases the decoder has to supply the read byte itself. A read of an unmapped address gives 0x00. A battery-RAM read gives 0x00 when no RAM is fitted. A program-ROM read while the coprocessor holds the bus gives back the floating bus byte. The one exception is the 64-byte vector window at the top of the first bank: that read is steered into the I/O space, so the host fetches the vectors that the coprocessor supplies. The block is purely combinational, and the memories and registers it selects live outside it.

Top module: `cart_map_decoder`

## Requirements
- R1: Program ROM is selected when address bit 22 is 0 and bit 15 is 1, or when bits 23 and 22 are both 1.
- R2: The ROM offset in map 0 places address bits 21:16 at offset bits 20:15 and address bits 14:0 at offset bits 14:0. In map 1 the ROM offset is address bits 21:0.
- R3: In map 0, battery RAM is selected when bits 23:19 equal 01110 and bit 15 is 0. Its offset is address bits 18:16 at offset bits 17:15 and address bits 14:0 below them.
- R4: In map 1, battery RAM is selected when bits 22:20 equal 011 and bits 15:13 equal 011. Its offset is address bits 19:16 at offset bits 16:13 and address bits 12:0 below them.
- R5: Data RAM is selected when bit 22 is 0, bits 15:13 equal 011 and bits 11:10 are not 11. In map 1 it is also rejected when bits 21:20 are 11. Its offset is address bits 11:0.
- R6: I/O is selected under the same bank and page conditions as data RAM but with bits 11:10 equal to 11, including the map-1 exclusion. Its offset is address bits 9:0.
- R7: The select `region_sel` has exactly one bit set, with bit 0 ROM, 1 battery RAM, 2 data RAM, 3 I/O and 4 unmapped. Where regions overlap, ROM wins, then battery RAM, then data RAM, then I/O.
- R8: An unmapped address gives offset 0. A read of it raises `local_rd_valid` with `local_rd_data` = 0x00.
- R9: The bus counts as owned while `cop_busy` is 1 and `cop_active` is 0. An owned ROM read never raises `rom_rd`. If the address has bit 23 and bits 21:16 zero and bits 15:6 equal to 0x3FF (map 1) or 0x1FF (map 0), the read selects I/O at offset 0x340 plus address bits 5:0 and raises `io_rd`. Any other owned ROM read returns `bus_in` through `local_rd_valid`/`local_rd_data`. The map-0 window already lies in the I/O decode, so in map 0 this case never arises.
- R10: When `ram_fitted` is 0, battery-RAM reads and writes raise no strobe, and reads return 0x00 through `local_rd_valid`.
- R11: Each region's read and write strobe equals the host request ANDed with that region's select. ROM has no write strobe. With no request pending, every strobe and `local_rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| map_mode | input | 1 | Memory-map strap, 0 or 1 |
| cop_busy | input | 1 | Coprocessor is running a program |
| cop_active | input | 1 | Coprocessor is itself on the bus this cycle |
| ram_fitted | input | 1 | Battery RAM is present |
| host_addr | input | 24 | Host bus address |
| host_rd | input | 1 | Host read request |
| host_wr | input | 1 | Host write request |
| bus_in | input | 8 | Floating bus byte |
| region_sel | output | 5 | One-hot region select |
| region_off | output | 22 | Linear offset in the selected region |
| rom_rd | output | 1 | ROM read strobe |
| bram_rd | output | 1 | Battery RAM read strobe |
| bram_wr | output | 1 | Battery RAM write strobe |
| dram_rd | output | 1 | Data RAM read strobe |
| dram_wr | output | 1 | Data RAM write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| local_rd_valid | output | 1 | Decoder supplies the read byte |
| local_rd_data | output | 8 | Byte supplied by the decoder |

## Verification
Addresses are built half from a set of bank and page boundary values and half at random. The boundary half separates the neighbouring decode masks: page 0x6BFF against 0x6C00, bank 0x2F against 0x30, bank 0x77 against 0x78, and 0x7FC0 and 0xFFC0 in bank 0x00 against bank 0x40. The map strap, the ownership bits, the RAM-fitted bit and the request type change every cycle, independently of each other. This shows that redirection depends on ownership and on a read, that the RAM suppression depends only on the fitted bit, and that the map-1 exclusion of banks 0x30 to 0x3F depends only on the strap.

// File: rtl/cmd_pkg.sv
package cmd_pkg;
    localparam int ADDR_W = 24;
    localparam int DATA_W = 8;
    localparam int OFF_W  = 22;
    localparam int NREG   = 5;
    localparam int IO_W   = 10;
    localparam int DRAM_W = 12;

    typedef enum logic [2:0] {
        RG_ROM  = 3'd0,
        RG_BRAM = 3'd1,
        RG_DRAM = 3'd2,
        RG_IO   = 3'd3,
        RG_NONE = 3'd4
    } region_e;

    typedef struct packed {
        logic             hit;
        logic [OFF_W-1:0] off;
    } hit_t;
endpackage

// File: rtl/cmd_rom_map.sv
module cmd_rom_map
    import cmd_pkg::*;
#(
    parameter int VEC_LSB = 6
) (
    input  logic              map_mode,
    input  logic [ADDR_W-1:0] addr,
    output hit_t              rom,
    output logic              vec_win
);
    localparam int WIN_HI_W = 16 - VEC_LSB;

    logic [OFF_W-1:0]    off_m0;
    logic [OFF_W-1:0]    off_m1;
    logic [WIN_HI_W-1:0] win_page;

    // map 0 folds each 32 KB half-bank together, map 1 is linear
    assign off_m0   = {1'b0, addr[21:16], addr[14:0]};
    assign off_m1   = addr[21:0];
    assign win_page = {map_mode, {(WIN_HI_W-1){1'b1}}};

    always_comb begin
        rom.hit = (!addr[22] && addr[15]) || (addr[23:22] == 2'b11);
        rom.off = map_mode ? off_m1 : off_m0;
        vec_win = !addr[23] && (addr[21:16] == 6'd0) &&
                  (addr[15:VEC_LSB] == win_page);
    end
endmodule

// File: rtl/cmd_bram_map.sv
module cmd_bram_map
    import cmd_pkg::*;
(
    input  logic              map_mode,
    input  logic [ADDR_W-1:0] addr,
    output hit_t              bram
);
    hit_t m0;
    hit_t m1;

    always_comb begin
        // map 0: banks 70-77, lower half of each bank
        m0.hit = (addr[23:19] == 5'b01110) && !addr[15];
        m0.off = {4'd0, addr[18:16], addr[14:0]};
        // map 1: banks 30-3f / b0-bf, 8 KB page at 6000
        m1.hit = (addr[22:20] == 3'b011) && (addr[15:13] == 3'b011);
        m1.off = {5'd0, addr[19:16], addr[12:0]};
        bram   = map_mode ? m1 : m0;
    end
endmodule

// File: rtl/cmd_int_map.sv
module cmd_int_map
    import cmd_pkg::*;
(
    input  logic              map_mode,
    input  logic [ADDR_W-1:0] addr,
    output hit_t              dram,
    output hit_t              io
);
    logic page_ok;
    logic bank_ok;
    logic io_page;
    logic unused_bits;

    assign unused_bits = ^{addr[23], addr[19:16], addr[12]};

    always_comb begin
        page_ok  = !addr[22] && (addr[15:13] == 3'b011);
        bank_ok  = !(map_mode && (addr[21:20] == 2'b11));
        io_page  = (addr[11:10] == 2'b11);
        dram.hit = page_ok && bank_ok && !io_page;
        dram.off = {{(OFF_W-DRAM_W){1'b0}}, addr[DRAM_W-1:0]};
        io.hit   = page_ok && bank_ok && io_page;
        io.off   = {{(OFF_W-IO_W){1'b0}}, addr[IO_W-1:0]};
    end
endmodule

// File: rtl/cart_map_decoder.sv
module cart_map_decoder
    import cmd_pkg::*;
#(
    parameter int              VEC_BYTES   = 64,
    parameter logic [IO_W-1:0] IO_VEC_BASE = 10'h340
) (
    input  logic              map_mode,
    input  logic              cop_busy,
    input  logic              cop_active,
    input  logic              ram_fitted,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] bus_in,
    output logic [NREG-1:0]   region_sel,
    output logic [OFF_W-1:0]  region_off,
    output logic              rom_rd,
    output logic              bram_rd,
    output logic              bram_wr,
    output logic              dram_rd,
    output logic              dram_wr,
    output logic              io_rd,
    output logic              io_wr,
    output logic              local_rd_valid,
    output logic [DATA_W-1:0] local_rd_data
);
    localparam int VEC_LSB = $clog2(VEC_BYTES);

    hit_t    rom_h, bram_h, dram_h, io_h;
    logic    vec_win;
    logic    owned;
    region_e rg;
    logic    redirect;

    cmd_rom_map #(.VEC_LSB(VEC_LSB)) u_rom (
        .map_mode (map_mode),
        .addr     (host_addr),
        .rom      (rom_h),
        .vec_win  (vec_win)
    );

    cmd_bram_map u_bram (
        .map_mode (map_mode),
        .addr     (host_addr),
        .bram     (bram_h)
    );

    cmd_int_map u_int (
        .map_mode (map_mode),
        .addr     (host_addr),
        .dram     (dram_h),
        .io       (io_h)
    );

    assign owned = cop_busy && !cop_active;

    // region choice, fixed priority
    always_comb begin
        rg         = RG_NONE;
        redirect   = 1'b0;
        region_off = '0;
        if (rom_h.hit) begin
            if (host_rd && owned && vec_win) begin
                rg                   = RG_IO;
                redirect             = 1'b1;
                region_off[IO_W-1:0] = IO_VEC_BASE |
                    {{(IO_W-VEC_LSB){1'b0}}, host_addr[VEC_LSB-1:0]};
            end else begin
                rg         = RG_ROM;
                region_off = rom_h.off;
            end
        end else if (bram_h.hit) begin
            rg         = RG_BRAM;
            region_off = bram_h.off;
        end else if (dram_h.hit) begin
            rg         = RG_DRAM;
            region_off = dram_h.off;
        end else if (io_h.hit) begin
            rg         = RG_IO;
            region_off = io_h.off;
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_sel
        assign region_sel[g] = (rg == region_e'(g));
    end

    // strobes and locally supplied read data
    always_comb begin
        rom_rd         = 1'b0;
        bram_rd        = 1'b0;
        bram_wr        = 1'b0;
        dram_rd        = 1'b0;
        dram_wr        = 1'b0;
        io_rd          = 1'b0;
        io_wr          = 1'b0;
        local_rd_valid = 1'b0;
        local_rd_data  = '0;
        unique case (rg)
            RG_ROM: begin
                rom_rd         = host_rd && !owned;
                local_rd_valid = host_rd && owned;
                local_rd_data  = owned ? bus_in : '0;
            end
            RG_BRAM: begin
                bram_rd        = host_rd && ram_fitted;
                bram_wr        = host_wr && ram_fitted;
                local_rd_valid = host_rd && !ram_fitted;
            end
            RG_DRAM: begin
                dram_rd = host_rd;
                dram_wr = host_wr;
            end
            RG_IO: begin
                io_rd = host_rd;
                io_wr = host_wr && !redirect;
            end
            RG_NONE: begin
                local_rd_valid = host_rd;
            end
            default: begin
                local_rd_valid = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/cart_map_decoder_chk.sv
module cart_map_decoder_chk
    import cmd_pkg::*;
(
    input logic              cop_busy,
    input logic              cop_active,
    input logic              ram_fitted,
    input logic              host_rd,
    input logic              host_wr,
    input logic [NREG-1:0]   region_sel,
    input logic [OFF_W-1:0]  region_off,
    input logic              rom_rd,
    input logic              bram_rd,
    input logic              bram_wr,
    input logic              dram_rd,
    input logic              dram_wr,
    input logic              io_rd,
    input logic              io_wr,
    input logic              local_rd_valid
);
    always_comb begin
        if (!$isunknown({host_addr_dummy(), region_sel}))
            AST_SEL_ONE_HOT: assert ($countones(region_sel) == 1) else $error("one-hot"); // R7
        if (!$isunknown({region_sel, region_off}))
            AST_NONE_ZERO_OFF: assert (!region_sel[4] || region_off == '0) else $error("none off"); // R8
        if (!$isunknown({region_sel, region_off}))
            AST_IO_OFF_RANGE: assert (!region_sel[3] || region_off[OFF_W-1:IO_W] == '0) else $error("io off"); // R6
        if (!$isunknown({region_sel, region_off}))
            AST_DRAM_BELOW_3K: assert (!region_sel[2] || (region_off[OFF_W-1:DRAM_W] == '0 && region_off[11:10] != 2'b11)) else $error("dram off"); // R5
        if (!$isunknown({cop_busy, cop_active, rom_rd}))
            AST_OWNED_NO_ROM: assert (!(cop_busy && !cop_active && rom_rd)) else $error("owned rom"); // R9
        if (!$isunknown({ram_fitted, bram_rd, bram_wr}))
            AST_NO_RAM_QUIET: assert (ram_fitted || !(bram_rd || bram_wr)) else $error("no ram"); // R10
        if (!$isunknown({host_rd, rom_rd, bram_rd, dram_rd, io_rd, local_rd_valid}))
            AST_RD_NEEDS_REQ: assert (host_rd || !(rom_rd || bram_rd || dram_rd || io_rd || local_rd_valid)) else $error("rd"); // R11
        if (!$isunknown({host_wr, bram_wr, dram_wr, io_wr}))
            AST_WR_NEEDS_REQ: assert (host_wr || !(bram_wr || dram_wr || io_wr)) else $error("wr"); // R11
    end

    function automatic logic host_addr_dummy();
        return 1'b0;
    endfunction
endmodule

bind cart_map_decoder cart_map_decoder_chk chk_i (
    .cop_busy       (cop_busy),
    .cop_active     (cop_active),
    .ram_fitted     (ram_fitted),
    .host_rd        (host_rd),
    .host_wr        (host_wr),
    .region_sel     (region_sel),
    .region_off     (region_off),
    .rom_rd         (rom_rd),
    .bram_rd        (bram_rd),
    .bram_wr        (bram_wr),
    .dram_rd        (dram_rd),
    .dram_wr        (dram_wr),
    .io_rd          (io_rd),
    .io_wr          (io_wr),
    .local_rd_valid (local_rd_valid)
);

// File: tb/cart_map_decoder_tb_top.sv
`timescale 1ns/1ps
module cart_map_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        map_mode, cop_busy, cop_active, ram_fitted;
    logic [23:0] host_addr;
    logic        host_rd, host_wr;
    logic [7:0]  bus_in;
    logic [4:0]  region_sel;
    logic [21:0] region_off;
    logic        rom_rd, bram_rd, bram_wr, dram_rd, dram_wr, io_rd, io_wr;
    logic        local_rd_valid;
    logic [7:0]  local_rd_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    cart_map_decoder dut_i (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s addr=%06h actual=%0h expected=%0h",
                     req, what, host_addr, act, exp);
        end
    endtask

    // behavioural reference, written from the requirements
    int e_sel, e_off, e_en, e_lv, e_ld;
    string e_tag;

    task automatic model();
        int a;
        bit rom, ram, dr, io, b3, own, win, rd, wr, m;
        a   = int'(host_addr);
        m   = map_mode;
        rd  = host_rd;
        wr  = host_wr;
        own = cop_busy && !cop_active;
        rom = ((a & 'h408000) == 'h008000) || ((a & 'hc00000) == 'hc00000);
        ram = m ? ((a & 'h70e000) == 'h306000) : ((a & 'hf88000) == 'h700000);
        b3  = (a & 'h300000) == 'h300000;
        dr  = ((a & 'h40e000) == 'h006000) && ((a & 'hc00) != 'hc00) && !(m && b3);
        io  = ((a & 'h40ec00) == 'h006c00) && !(m && b3);
        e_en = 0; e_lv = 0; e_ld = 0; e_off = 0;
        // e_en bits: 6 rom_rd 5 bram_rd 4 bram_wr 3 dram_rd 2 dram_wr 1 io_rd 0 io_wr
        if (rom) begin
            win = (a & 'hbfffc0) == (m ? 'h00ffc0 : 'h007fc0);
            if (rd && own && win) begin
                e_sel = 8; e_off = 'h340 | (a & 'h3f); e_en = 2; e_tag = "R9";
            end else begin
                e_sel = 1; e_tag = own ? "R9" : "R1";
                e_off = m ? (a & 'h3fffff)
                          : ((((a & 'h3f0000) >> 1) | (a & 'h7fff)) & 'h1fffff);
                e_en  = (rd && !own) ? 64 : 0;
                e_lv  = rd && own;
                e_ld  = bus_in;
            end
        end else if (ram) begin
            e_sel = 2; e_tag = ram_fitted ? (m ? "R4" : "R3") : "R10";
            e_off = m ? ((((a & 'h0f0000) >> 3) | (a & 'h1fff)) & 'h1ffff)
                      : ((((a & 'h070000) >> 1) | (a & 'h7fff)) & 'h3ffff);
            e_en  = ram_fitted ? ((rd ? 32 : 0) | (wr ? 16 : 0)) : 0;
            e_lv  = rd && !ram_fitted;
        end else if (dr) begin
            e_sel = 4; e_tag = "R5"; e_off = a & 'hfff;
            e_en  = (rd ? 8 : 0) | (wr ? 4 : 0);
        end else if (io) begin
            e_sel = 8; e_tag = "R6"; e_off = a & 'h3ff;
            e_en  = (rd ? 2 : 0) | (wr ? 1 : 0);
        end else begin
            e_sel = 16; e_tag = "R8"; e_lv = rd;
        end
    endtask

    task automatic compare();
        int en;
        en = {rom_rd, bram_rd, bram_wr, dram_rd, dram_wr, io_rd, io_wr};
        model();
        check($countones(region_sel) == 1, "R7", "onehot", region_sel, e_sel);
        check(region_sel == e_sel, e_tag, "region", region_sel, e_sel);
        check(region_off == e_off, (e_sel == 1) ? "R2" : e_tag, "offset", region_off, e_off);
        check(en == e_en, (e_tag == "R1") ? "R11" : e_tag, "strobes", en, e_en);
        check(local_rd_valid == e_lv, e_tag, "local_valid", local_rd_valid, e_lv);
        if (e_lv) check(local_rd_data == e_ld, e_tag, "local_data", local_rd_data, e_ld);
    endtask

    function automatic logic [23:0] pick_addr();
        logic [7:0]  banks [15] = '{8'h00, 8'h2f, 8'h30, 8'h3f, 8'h40, 8'h70, 8'h77,
                                    8'h78, 8'h80, 8'haf, 8'hb0, 8'hbf, 8'hc0, 8'hff, 8'h31};
        logic [15:0] pages [16] = '{16'h6000, 16'h6bff, 16'h6c00, 16'h6fff, 16'h7000,
                                    16'h7bff, 16'h7c00, 16'h7fc0, 16'h7fff, 16'h8000,
                                    16'hffc0, 16'hffff, 16'h0000, 16'h5fff, 16'he000,
                                    16'hffc5};
        logic [7:0]  b;
        logic [15:0] p;
        b = ($urandom % 2) ? banks[$urandom % 15] : 8'($urandom);
        p = ($urandom % 2) ? pages[$urandom % 16] : 16'($urandom);
        return {b, p};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        map_mode = 0; cop_busy = 0; cop_active = 0; ram_fitted = 1;
        host_addr = '0; host_rd = 0; host_wr = 0; bus_in = 8'h5a;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: idle request gives no strobe
        check({rom_rd, bram_rd, bram_wr, dram_rd, dram_wr, io_rd, io_wr, local_rd_valid} == 0,
              "R11", "idle strobes", 0, 0);
        rst = 1'b0;
        // directed R9 corner: map 1 owned vector read
        @(posedge clk);
        map_mode = 1; cop_busy = 1; cop_active = 0; host_addr = 24'h00ffc5; host_rd = 1;
        @(negedge clk);
        check(io_rd && region_off == 22'h345, "R9", "vector redirect", region_off, 'h345);
        compare();
        for (int i = 0; i < 8000; i++) begin
            int op;
            @(posedge clk);
            op         = $urandom % 3;
            map_mode   = 1'($urandom);
            cop_busy   = 1'($urandom);
            cop_active = 1'($urandom);
            ram_fitted = 1'($urandom);
            bus_in     = 8'($urandom);
            host_addr  = pick_addr();
            host_rd    = (op == 1);
            host_wr    = (op == 2);
            @(negedge clk);
            compare();
        end
        finish_run();
    end

    initial begin
        #200000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule